// File: doc/BRIEF.md
# Upper-Memory Shadow Attribute Decoder

This block turns three chipset control bytes and a 20-bit memory address into routing attributes for the upper-memory ROM window from C0000h to FFFFFh. For each address it reports where a read is served from (internal DRAM or the external bus) and what happens to a write (stored in internal DRAM, passed to the external bus, or dropped). Address decoders elsewhere in the memory controller consult these attributes on every access. This lets firmware copy slow ROM images into DRAM, run from the copies and then write-protect them.

The window has three kinds of area. Four 16 KB segments start at C0000h, eight 16 KB segments start at D0000h, and one 64 KB system firmware segment starts at F0000h. Each 16 KB segment has its own shadow enable. Write protection is shared by larger groups: one bit covers the C area, one the D area and one the E area. A global fallback bit decides how segments without shadowing behave. The firmware segment swaps its read and write sources together under a single bit. The block is purely combinational and has no clock or reset.

Top module: `shadow_attr_decoder`

## Requirements
- R1: When bit 7 of `ctl_bios` is 1, any address F0000h–FFFFFh gives `rd_src`=01 (external) and `wr_tgt`=00 (internal).
- R2: When bit 7 of `ctl_bios` is 0, any address F0000h–FFFFFh gives `rd_src`=00 (internal) and `wr_tgt`=10 (discarded).
- R3: For the segment k = (addr − D0000h) >> 14, k in 0..7, bit k of `ctl_hi_en` set gives `rd_src`=00 (internal).
- R4: The write-protect bit for E0000h–EFFFFh is bit 3 of `ctl_bios`, and for D0000h–DFFFFh it is bit 4. For an enabled segment, a set protect bit gives `wr_tgt`=10 and a clear one gives `wr_tgt`=00.
- R5: For the segment k = addr[15:14] in C0000h–CFFFFh, bit k (0..3) of `ctl_lo` set gives `rd_src`=00. The write is then 10 if bit 5 of `ctl_lo` is set and 00 otherwise.
- R6: For a segment whose enable bit is clear, when bit 6 of `ctl_lo` is set, `rd_src` is 01. `wr_tgt` follows that segment's protect bit (10 if set, 00 if clear).
- R7: For a segment whose enable bit is clear, when bit 6 of `ctl_lo` is clear, `rd_src`=01 and `wr_tgt`=01.
- R8: Addresses below C0000h give `in_range`=0, `rd_src`=01 and `wr_tgt`=01. Addresses at C0000h or above give `in_range`=1.
- R9: `rd_src` never takes the values 10 or 11, and `wr_tgt` never takes 11.
- R10: Every address within one segment gives the same attributes. The first and last byte of each segment agree.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctl_bios | input | 8 | Firmware-segment swap (bit 7), E-area protect (bit 3), D-area protect (bit 4) |
| ctl_hi_en | input | 8 | Shadow enable per 16 KB segment from D0000h, bit k for segment k |
| ctl_lo | input | 8 | C-segment enables (bits 3:0), C-area protect (bit 5), fallback for unshadowed segments (bit 6) |
| addr | input | 20 | Memory address being classified |
| rd_src | output | 2 | Read source: 00 internal DRAM, 01 external bus |
| wr_tgt | output | 2 | Write target: 00 internal DRAM, 01 external bus, 10 discarded |
| in_range | output | 1 | 1 when the address lies in C0000h–FFFFFh |

## Verification
The bound checker tests the firmware-segment swap, the out-of-window default, the legality of the output codes and the fully external routing of unshadowed segments on every evaluation. It also checks that an internal read only ever comes from an enabled segment or the unswapped firmware segment. Several properties need the bench's scenarios: the split of protect bits between the D and E areas, the fallback write routing that shares the protect bit, and uniform attributes across a whole segment. The bench checks these with directed cases and with a sweep that compares every segment boundary against an independent model over combinations of the control bits.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

   // Read source encoding
   typedef enum logic [1:0] {
      RD_INTERNAL = 2'b00,
      RD_EXTERNAL = 2'b01
   } rd_src_e;

   // Write target encoding
   typedef enum logic [1:0] {
      WR_INTERNAL = 2'b00,
      WR_EXTERNAL = 2'b01,
      WR_DISCARD  = 2'b10
   } wr_tgt_e;

   // Which kind of area an address falls in
   typedef enum logic [1:0] {
      AREA_NONE = 2'b00,
      AREA_LO   = 2'b01,
      AREA_HI   = 2'b10,
      AREA_BIOS = 2'b11
   } area_e;

   typedef struct packed {
      rd_src_e rd;
      wr_tgt_e wr;
   } attr_t;

   // Control bit positions; neighbouring register logic decodes them
   localparam int BIOS_SWAP_BIT = 7;
   localparam int HI_PROT_BIT   = 3;
   localparam int MID_PROT_BIT  = 4;
   localparam int LO_PROT_BIT   = 5;
   localparam int FALLBACK_BIT  = 6;

   localparam attr_t ATTR_ALL_EXT = '{rd: RD_EXTERNAL, wr: WR_EXTERNAL};

endpackage

// File: rtl/shadow_region_locate.sv
module shadow_region_locate
   import shadow_pkg::*;
#(
   parameter int              ADDR_W     = 20,
   parameter int              SEG_SHIFT  = 14,
   parameter int              BIOS_SHIFT = 16,
   parameter int              LO_SEGS    = 4,
   parameter int              HI_SEGS    = 8,
   parameter int              IDX_W      = 3,
   parameter logic [ADDR_W:0] LO_BASE    = 21'h0C0000
) (
   input  logic [ADDR_W-1:0] addr,
   output area_e             area,
   output logic [IDX_W-1:0]  seg_idx
);

   localparam logic [ADDR_W:0] SEG_SIZE  = (ADDR_W+1)'(1) << SEG_SHIFT;
   localparam logic [ADDR_W:0] BIOS_SIZE = (ADDR_W+1)'(1) << BIOS_SHIFT;
   localparam logic [ADDR_W:0] HI_BASE   = LO_BASE + SEG_SIZE * (ADDR_W+1)'(LO_SEGS);
   localparam logic [ADDR_W:0] BIOS_BASE = HI_BASE + SEG_SIZE * (ADDR_W+1)'(HI_SEGS);
   localparam logic [ADDR_W:0] TOP_END   = BIOS_BASE + BIOS_SIZE;

   logic [ADDR_W:0] a_ext;
   logic [ADDR_W:0] off_lo;
   logic [ADDR_W:0] off_hi;

   assign a_ext  = {1'b0, addr};
   assign off_lo = a_ext - LO_BASE;
   assign off_hi = a_ext - HI_BASE;

   always_comb begin
      area    = AREA_NONE;
      seg_idx = '0;
      if (a_ext >= BIOS_BASE && a_ext < TOP_END) begin
         area = AREA_BIOS;
      end else if (a_ext >= HI_BASE && a_ext < BIOS_BASE) begin
         area    = AREA_HI;
         seg_idx = IDX_W'(off_hi >> SEG_SHIFT);
      end else if (a_ext >= LO_BASE && a_ext < HI_BASE) begin
         area    = AREA_LO;
         seg_idx = IDX_W'(off_lo >> SEG_SHIFT);
      end
   end

endmodule

// File: rtl/shadow_seg_attr.sv
module shadow_seg_attr
   import shadow_pkg::*;
(
   input  logic  seg_en,
   input  logic  wr_prot,
   input  logic  fallback,
   output attr_t attr
);

   wr_tgt_e prot_wr;

   assign prot_wr = wr_prot ? WR_DISCARD : WR_INTERNAL;

   always_comb begin
      if (seg_en) begin
         attr.rd = RD_INTERNAL;
         attr.wr = prot_wr;
      end else if (fallback) begin
         attr.rd = RD_EXTERNAL;
         attr.wr = prot_wr;
      end else begin
         attr = ATTR_ALL_EXT;
      end
   end

endmodule

// File: rtl/shadow_attr_decoder.sv
module shadow_attr_decoder
   import shadow_pkg::*;
#(
   parameter int ADDR_W        = 20,
   parameter int SEG_SHIFT     = 14,
   parameter int BIOS_SHIFT    = 16,
   parameter int LO_SEGS       = 4,
   parameter int HI_SEGS       = 8,
   parameter int HI_PROT_SPLIT = 4,
   parameter int CTL_W         = 8
) (
   input  logic [CTL_W-1:0]  ctl_bios,
   input  logic [CTL_W-1:0]  ctl_hi_en,
   input  logic [CTL_W-1:0]  ctl_lo,
   input  logic [ADDR_W-1:0] addr,
   output logic [1:0]        rd_src,
   output logic [1:0]        wr_tgt,
   output logic              in_range
);

   localparam int LO_IDX_W = $clog2(LO_SEGS);
   localparam int HI_IDX_W = $clog2(HI_SEGS);
   localparam int IDX_W    = (LO_IDX_W > HI_IDX_W) ? LO_IDX_W : HI_IDX_W;
   localparam logic [ADDR_W:0] LO_BASE = (ADDR_W+1)'(20'hC0000);
   localparam longint WINDOW_END = longint'(LO_BASE)
                                 + (longint'(LO_SEGS + HI_SEGS) << SEG_SHIFT)
                                 + (longint'(1) << BIOS_SHIFT);

   // Elaboration-time parameter checks
   if (ADDR_W < 20)                           $error("ADDR_W must cover the 1 MB map");
   if (LO_SEGS < 2 || HI_SEGS < 2)            $error("segment counts must be at least 2");
   if (LO_SEGS > CTL_W - 4)                   $error("low enables overlap control bits");
   if (HI_SEGS > CTL_W)                       $error("high enables exceed control width");
   if (HI_PROT_SPLIT > HI_SEGS)               $error("protect split beyond high segments");
   if (WINDOW_END > (longint'(1) << ADDR_W))  $error("window exceeds address space");

   area_e            area;
   logic [IDX_W-1:0] seg_idx;
   attr_t            lo_attr [LO_SEGS];
   attr_t            hi_attr [HI_SEGS];
   attr_t            bios_attr;
   attr_t            sel_attr;

   shadow_region_locate #(
      .ADDR_W     (ADDR_W),
      .SEG_SHIFT  (SEG_SHIFT),
      .BIOS_SHIFT (BIOS_SHIFT),
      .LO_SEGS    (LO_SEGS),
      .HI_SEGS    (HI_SEGS),
      .IDX_W      (IDX_W),
      .LO_BASE    (LO_BASE)
   ) u_locate (
      .addr    (addr),
      .area    (area),
      .seg_idx (seg_idx)
   );

   // Low area: one enable per segment, one shared protect bit
   for (genvar gi = 0; gi < LO_SEGS; gi++) begin : g_lo
      shadow_seg_attr u_seg (
         .seg_en   (ctl_lo[gi]),
         .wr_prot  (ctl_lo[LO_PROT_BIT]),
         .fallback (ctl_lo[FALLBACK_BIT]),
         .attr     (lo_attr[gi])
      );
   end

   // High area: protect bit chosen by which half the segment sits in
   for (genvar gi = 0; gi < HI_SEGS; gi++) begin : g_hi
      logic prot;
      if (gi >= HI_PROT_SPLIT) begin : g_upper
         assign prot = ctl_bios[HI_PROT_BIT];
      end else begin : g_lower
         assign prot = ctl_bios[MID_PROT_BIT];
      end
      shadow_seg_attr u_seg (
         .seg_en   (ctl_hi_en[gi]),
         .wr_prot  (prot),
         .fallback (ctl_lo[FALLBACK_BIT]),
         .attr     (hi_attr[gi])
      );
   end

   // Firmware segment swaps both directions together
   always_comb begin
      if (ctl_bios[BIOS_SWAP_BIT]) begin
         bios_attr.rd = RD_EXTERNAL;
         bios_attr.wr = WR_INTERNAL;
      end else begin
         bios_attr.rd = RD_INTERNAL;
         bios_attr.wr = WR_DISCARD;
      end
   end

   always_comb begin
      sel_attr = ATTR_ALL_EXT;
      in_range = 1'b1;
      case (area)
         AREA_LO:   sel_attr = lo_attr[seg_idx[LO_IDX_W-1:0]];
         AREA_HI:   sel_attr = hi_attr[seg_idx[HI_IDX_W-1:0]];
         AREA_BIOS: sel_attr = bios_attr;
         default:   in_range = 1'b0;
      endcase
   end

   assign rd_src = sel_attr.rd;
   assign wr_tgt = sel_attr.wr;

endmodule

// File: rtl/shadow_attr_checker.sv
module shadow_attr_checker #(
   parameter int ADDR_W = 20,
   parameter int CTL_W  = 8
) (
   input logic [CTL_W-1:0]  ctl_bios,
   input logic [CTL_W-1:0]  ctl_hi_en,
   input logic [CTL_W-1:0]  ctl_lo,
   input logic [ADDR_W-1:0] addr,
   input logic [1:0]        rd_src,
   input logic [1:0]        wr_tgt,
   input logic              in_range
);

   logic       top_clear;
   logic       in_f;
   logic       in_de;
   logic       in_c;
   logic [2:0] hi_k;
   logic [1:0] lo_k;
   logic       seg_on;

   assign top_clear = (addr >> 20) == '0;
   assign in_f  = top_clear && addr[19:16] == 4'hF;
   assign in_de = top_clear && (addr[19:16] == 4'hD || addr[19:16] == 4'hE);
   assign in_c  = top_clear && addr[19:16] == 4'hC;
   assign hi_k  = {addr[19:16] == 4'hE, addr[15:14]};
   assign lo_k  = addr[15:14];
   assign seg_on = in_de ? ctl_hi_en[hi_k] : (in_c ? ctl_lo[lo_k] : 1'b0);

   always_comb begin
      // R9: only legal codes appear
      a_r9_legal_codes: assert (rd_src[1] == 1'b0 && wr_tgt != 2'b11)
         else $error("illegal attribute code rd=%b wr=%b", rd_src, wr_tgt);

      // R8: outside the window everything goes external
      if (!in_range)
         a_r8_outside_external: assert (rd_src == 2'b01 && wr_tgt == 2'b01)
            else $error("out-of-window attributes rd=%b wr=%b", rd_src, wr_tgt);

      // R1: swapped firmware segment
      if (in_f && ctl_bios[7])
         a_r1_bios_swapped: assert (in_range && rd_src == 2'b01 && wr_tgt == 2'b00)
            else $error("firmware swap attributes rd=%b wr=%b", rd_src, wr_tgt);

      // R2: unswapped firmware segment
      if (in_f && !ctl_bios[7])
         a_r2_bios_shadowed: assert (in_range && rd_src == 2'b00 && wr_tgt == 2'b10)
            else $error("firmware shadow attributes rd=%b wr=%b", rd_src, wr_tgt);

      // R7: unshadowed segment without fallback is fully external
      if ((in_de || in_c) && !seg_on && !ctl_lo[6])
         a_r7_unshadowed_external: assert (rd_src == 2'b01 && wr_tgt == 2'b01)
            else $error("unshadowed segment attributes rd=%b wr=%b", rd_src, wr_tgt);

      // R3 / R5: an internal read needs an enabled segment or the firmware shadow
      if (rd_src == 2'b00)
         a_r3_internal_read_source: assert (seg_on || (in_f && !ctl_bios[7]))
            else $error("internal read without enable at %h", addr);
   end

endmodule

bind shadow_attr_decoder shadow_attr_checker #(.ADDR_W(ADDR_W), .CTL_W(CTL_W)) u_chk (.*);

// File: tb/shadow_attr_decoder_tb.sv
module shadow_attr_decoder_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 200000;

   logic       clk = 1'b0;
   logic [7:0] ctl_bios, ctl_hi_en, ctl_lo;
   logic [19:0] addr;
   logic [1:0] rd_src, wr_tgt;
   logic       in_range;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shadow_attr_decoder dut_i (
      .ctl_bios  (ctl_bios),
      .ctl_hi_en (ctl_hi_en),
      .ctl_lo    (ctl_lo),
      .addr      (addr),
      .rd_src    (rd_src),
      .wr_tgt    (wr_tgt),
      .in_range  (in_range)
   );

   // Independent model built from the requirement text
   function automatic void model(input logic [7:0] b, input logic [7:0] h,
                                 input logic [7:0] l, input logic [19:0] a,
                                 output logic [1:0] r, output logic [1:0] w,
                                 output logic inr);
      logic en, prot;
      r = 2'b01; w = 2'b01; inr = (a >= 20'hC0000);
      if (a >= 20'hF0000) begin
         if (b[7]) begin r = 2'b01; w = 2'b00; end
         else      begin r = 2'b00; w = 2'b10; end
      end else if (a >= 20'hC0000) begin
         if (a >= 20'hD0000) begin
            en   = h[(a - 20'hD0000) >> 14];
            prot = (a >= 20'hE0000) ? b[3] : b[4];
         end else begin
            en   = l[a[15:14]];
            prot = l[5];
         end
         if (en)        begin r = 2'b00; w = prot ? 2'b10 : 2'b00; end
         else if (l[6]) begin r = 2'b01; w = prot ? 2'b10 : 2'b00; end
      end
   endfunction

   task automatic drive(input logic [7:0] b, input logic [7:0] h,
                        input logic [7:0] l, input logic [19:0] a);
      @(negedge clk);
      ctl_bios = b; ctl_hi_en = h; ctl_lo = l; addr = a;
      #2;
   endtask

   task automatic check(input string tag, input logic [7:0] b, input logic [7:0] h,
                        input logic [7:0] l, input logic [19:0] a);
      logic [1:0] er, ew;
      logic ei;
      drive(b, h, l, a);
      model(b, h, l, a, er, ew, ei);
      n_checks++;
      if (rd_src !== er || wr_tgt !== ew || in_range !== ei) begin
         n_fails++;
         $display("FAIL %s addr=%h rd/wr/in actual=%b/%b/%b expected=%b/%b/%b",
                  tag, a, rd_src, wr_tgt, in_range, er, ew, ei);
      end
      n_checks++;
      if (rd_src[1] !== 1'b0 || wr_tgt === 2'b11) begin
         n_fails++;
         $display("FAIL R9 addr=%h actual rd=%b wr=%b expected legal codes", a, rd_src, wr_tgt);
      end
   endtask

   task automatic t_idle_state;
      check("R8", 8'h00, 8'h00, 8'h00, 20'h00000);
   endtask

   task automatic t_bios;
      check("R1", 8'h80, 8'h00, 8'h00, 20'hF0000);
      check("R1", 8'hFF, 8'hFF, 8'hFF, 20'hFFFFF);
      check("R2", 8'h00, 8'h00, 8'h00, 20'hF8000);
      check("R2", 8'h7F, 8'hFF, 8'hFF, 20'hFFFFF);
   endtask

   task automatic t_hi_enabled;
      for (int k = 0; k < 8; k++) begin
         check("R3", 8'h00, 8'(1 << k), 8'h00, 20'hD0000 + 20'(k << 14));
      end
      check("R4", 8'h08, 8'hFF, 8'h00, 20'hE4000);
      check("R4", 8'h10, 8'hFF, 8'h00, 20'hE4000);
      check("R4", 8'h10, 8'hFF, 8'h00, 20'hD8000);
      check("R4", 8'h08, 8'hFF, 8'h00, 20'hDC000);
   endtask

   task automatic t_lo_enabled;
      for (int k = 0; k < 4; k++) begin
         check("R5", 8'h00, 8'h00, 8'(1 << k), 20'hC0000 + 20'(k << 14));
         check("R5", 8'h00, 8'h00, 8'h20 | 8'(1 << k), 20'hC3FFF + 20'(k << 14));
      end
   endtask

   task automatic t_fallback;
      check("R6", 8'h08, 8'h00, 8'h40, 20'hE0000);
      check("R6", 8'h00, 8'h00, 8'h40, 20'hE0000);
      check("R6", 8'h10, 8'h00, 8'h40, 20'hD4000);
      check("R6", 8'h00, 8'h00, 8'h60, 20'hC8000);
      check("R7", 8'h18, 8'h00, 8'h20, 20'hE0000);
      check("R7", 8'h18, 8'hFE, 8'h2E, 20'hC0000);
      check("R7", 8'h18, 8'hFE, 8'h00, 20'hD0000);
   endtask

   task automatic t_outside;
      check("R8", 8'hFF, 8'hFF, 8'hFF, 20'hBFFFF);
      check("R8", 8'h00, 8'hFF, 8'h7F, 20'h9A000);
      check("R8", 8'hFF, 8'hFF, 8'hFF, 20'hC0000);
   endtask

   task automatic t_sweep;
      logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
      for (int bb = 0; bb < 8; bb++) begin
         for (int ll = 0; ll < 4; ll++) begin
            for (int p = 0; p < 4; p++) begin
               for (int s = 0; s < 13; s++) begin
                  logic [7:0]  b, l;
                  logic [19:0] base;
                  b = {bb[2], 3'b000, bb[1], bb[0], 3'b000} | 8'h44;
                  l = {1'b0, ll[1], ll[0], 1'b0, pats[p][7:4]};
                  base = (s < 12) ? 20'hC0000 + 20'(s << 14) : 20'hF0000;
                  check("R10", b, pats[p], l, base);
                  check("R10", b, pats[p], l, base + ((s < 12) ? 20'h03FFF : 20'h0FFFF));
               end
            end
         end
      end
   endtask

   initial begin
      ctl_bios = '0; ctl_hi_en = '0; ctl_lo = '0; addr = '0;
      t_idle_state();
      t_bios();
      t_hi_enabled();
      t_lo_enabled();
      t_fallback();
      t_outside();
      t_sweep();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule